// File: doc/BRIEF.md
# Prioritized Interrupt Entry Sequencer

This block gathers a set of peripheral request lines and turns them into a sequence of handler entries for a processor core. Each line is set to be edge or level sensitive. Edge events are kept in a pending flag. Level lines are read as they are at each cycle. A request can win only when its enable bit is set. Among the eligible requests, the one with the lowest index wins.

A four-state sequencer (idle, stacking, executing, unstacking) talks to the core through pulse handshakes. It asks the core to save context. After the core reports that stacking is done, it issues the vector to run. When the core reports that the handler is done, it either asks for context restore or goes straight to the next handler.

The sequencer also shortens the gaps between handlers in three ways:
- Tail chaining skips the restore/save pair when another request is waiting at handler end.
- Late arrival picks the winner only when stacking completes, so a request that arrives during stacking and outranks the first one is served first.
- Pop preemption drops a restore that is in progress when a new request shows up.

Top module: `irq_entry_seq`

## Requirements
- R1: When more than one request is eligible, the request with the smallest index is dispatched first (index 0 has the highest priority).
- R2: A rising edge on an edge-configured line (`irq_edge_sel` bit = 1) sets a pending flag, even if the pulse lasts one cycle. That flag is cleared when its handler is dispatched, so one edge produces exactly one handler entry.
- R3: A level-configured line (`irq_edge_sel` bit = 0) requests service for as long as it is high. It leaves no latched copy: a high level that goes away while the line is disabled causes no entry later.
- R4: A request with its `irq_en` bit at 0 is never dispatched. An edge that arrives while its line is disabled stays pending and is served once the line is enabled.
- R5: A one-cycle pulse on `sw_clr` bit k discards the pending edge of line k, so no entry follows when the line is enabled later.
- R6: If a new rising edge and an `sw_clr` pulse hit the same line in the same cycle, the edge wins and the flag stays set.
- R7: From idle, `stack_start` pulses for one cycle in the cycle after an eligible request is first visible. `irq_active` is high from then on. The cycle after `stack_done`, `dispatch` pulses for one cycle and `handler_vector` carries the winning index.
- R8: Tail chaining: if a request is eligible when `handler_done` arrives, the next cycle shows `dispatch` with the new vector. No `unstack_start` or `stack_start` is issued between the two handlers.
- R9: Late arrival: the winner is chosen in the cycle `stack_done` is seen. A higher-priority request that became pending during stacking is dispatched first, and the earlier one follows by tail chaining.
- R10: Pop preemption: if a request is eligible during unstacking, it is dispatched in the next cycle without waiting for `unstack_done`, and no `stack_start` is issued.
- R11: With no eligible request, `handler_done` leads to a one-cycle `unstack_start`. After `unstack_done`, `irq_active` is low in the next cycle.
- R12: When several edges arrive in the same cycle, exactly one is dispatched per entry and none of the others is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | N_SRC | Peripheral request lines |
| irq_edge_sel | input | N_SRC | 1 = edge sensitive, 0 = level sensitive, per line |
| irq_en | input | N_SRC | Per-line enable |
| sw_clr | input | N_SRC | One-cycle pulse per line that discards a pending edge |
| stack_start | output | 1 | Pulse: core should begin saving context |
| stack_done | input | 1 | Pulse from core: context saved |
| dispatch | output | 1 | Pulse: `handler_vector` holds a new handler to enter |
| handler_vector | output | $clog2(N_SRC) | Index of the dispatched line |
| handler_done | input | 1 | Pulse from core: current handler finished |
| unstack_start | output | 1 | Pulse: core should begin restoring context |
| unstack_done | input | 1 | Pulse from core: context restored |
| irq_active | output | 1 | High whenever the sequencer is out of idle |

## Verification
The hardest cases to reach from the ports are the two races that hinge on exact timing against the core handshake.

For pop preemption, the bench holds off `unstack_done` and raises a new edge in the cycle right after `unstack_start`. It then checks that a dispatch comes out while unstacking is still open.

For late arrival, a higher-priority edge is pulsed after `stack_start` but before `stack_done` is returned.

A full sweep over every ordered pair of simultaneous edges covers priority, tail chaining and the one-shot clearing of pending flags together.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int N_SRC = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_SRC-1:0]         irq_in,
  input  logic [N_SRC-1:0]         irq_edge_sel,
  input  logic [N_SRC-1:0]         irq_en,
  input  logic [N_SRC-1:0]         sw_clr,
  output logic                     stack_start,
  input  logic                     stack_done,
  output logic                     dispatch,
  output logic [$clog2(N_SRC)-1:0] handler_vector,
  input  logic                     handler_done,
  output logic                     unstack_start,
  input  logic                     unstack_done,
  output logic                     irq_active
);
  localparam int VW = $clog2(N_SRC);

  typedef enum logic [1:0] {S_IDLE, S_STACK, S_EXEC, S_UNSTACK} seq_t;

  seq_t             st, st_nx;
  logic [N_SRC-1:0] irq_q, pend, req, taken;
  logic [VW-1:0]    win;
  logic             any, go, ss_nx, us_nx;

  wire [N_SRC-1:0] rise = irq_in & ~irq_q & irq_edge_sel;

  assign req        = irq_en & ((irq_edge_sel & pend) | (~irq_edge_sel & irq_in));
  assign any        = |req;
  assign irq_active = (st != S_IDLE);

  always_comb begin
    win = '0;
    for (int k = N_SRC - 1; k >= 0; k--)
      if (req[k]) win = VW'(k);
  end

  always_comb begin
    st_nx = st;
    go    = 1'b0;
    ss_nx = 1'b0;
    us_nx = 1'b0;
    case (st)
      S_IDLE:
        if (any) begin
          st_nx = S_STACK;
          ss_nx = 1'b1;
        end
      S_STACK:
        if (stack_done) begin
          if (any) go = 1'b1;
          else begin
            st_nx = S_UNSTACK;
            us_nx = 1'b1;
          end
        end
      S_EXEC:
        if (handler_done) begin
          if (any) go = 1'b1;
          else begin
            st_nx = S_UNSTACK;
            us_nx = 1'b1;
          end
        end
      S_UNSTACK:
        if (any) go = 1'b1;
        else if (unstack_done) st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
    if (go) st_nx = S_EXEC;
  end

  assign taken = go ? (N_SRC'(1) << win) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st             <= S_IDLE;
      irq_q          <= '0;
      pend           <= '0;
      stack_start    <= 1'b0;
      unstack_start  <= 1'b0;
      dispatch       <= 1'b0;
      handler_vector <= '0;
    end else begin
      st            <= st_nx;
      irq_q         <= irq_in;
      pend          <= (pend & ~sw_clr & ~taken) | rise;
      stack_start   <= ss_nx;
      unstack_start <= us_nx;
      dispatch      <= go;
      if (go) handler_vector <= win;
    end
  end
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int N_SRC = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [N_SRC-1:0]         irq_en,
  input logic                     stack_start,
  input logic                     dispatch,
  input logic [$clog2(N_SRC)-1:0] handler_vector,
  input logic                     unstack_start,
  input logic                     unstack_done,
  input logic                     irq_active
);
  assert_enabled_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch |-> ((($past(irq_en)) >> handler_vector) & N_SRC'(1)) != '0);

  assert_dispatch_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch |-> irq_active);

  assert_entry_from_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stack_start |-> !$past(irq_active));

  assert_vector_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !dispatch |-> $stable(handler_vector));

  assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stack_start, dispatch, unstack_start}));

  assert_idle_after_restore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_active) |-> $past(unstack_done));
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .stack_start(stack_start),
  .dispatch(dispatch), .handler_vector(handler_vector),
  .unstack_start(unstack_start), .unstack_done(unstack_done),
  .irq_active(irq_active)
);

// File: tb/sim_irq_entry_seq.sv
`timescale 1ns/1ps
module sim_irq_entry_seq;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] irq_in = '0, irq_edge_sel = '1, irq_en = '1, sw_clr = '0;
  logic         stack_done = 1'b0, handler_done = 1'b0, unstack_done = 1'b0;
  logic         stack_start, dispatch, unstack_start, irq_active;
  logic [2:0]   handler_vector;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  irq_entry_seq #(.N_SRC(N)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .irq_edge_sel(irq_edge_sel),
    .irq_en(irq_en), .sw_clr(sw_clr), .stack_start(stack_start),
    .stack_done(stack_done), .dispatch(dispatch), .handler_vector(handler_vector),
    .handler_done(handler_done), .unstack_start(unstack_start),
    .unstack_done(unstack_done), .irq_active(irq_active)
  );

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse(input logic [N-1:0] m);
    irq_in = irq_in | m;
    step();
    irq_in = irq_in & ~m;
  endtask

  task automatic wait_ss();
    int seen = 0;
    for (int t = 0; t < 6 && seen == 0; t++) begin
      step();
      if (stack_start) seen = 1;
    end
    chk("R7 stack_start", seen, 1);
    chk("R7 irq_active", int'(irq_active), 1);
  endtask

  task automatic do_stack(input int v);
    stack_done = 1'b1;
    step();
    stack_done = 1'b0;
    chk("R7 dispatch", int'(dispatch), 1);
    chk("R1 vector", int'(handler_vector), v);
  endtask

  task automatic end_handler(input int v);
    handler_done = 1'b1;
    step();
    handler_done = 1'b0;
    if (v >= 0) begin
      chk("R8 tail dispatch", int'(dispatch), 1);
      chk("R8 tail vector", int'(handler_vector), v);
      chk("R8 no unstack", int'(unstack_start), 0);
    end else begin
      chk("R11 unstack_start", int'(unstack_start), 1);
    end
  endtask

  task automatic do_unstack();
    unstack_done = 1'b1;
    step();
    unstack_done = 1'b0;
    chk("R11 idle", int'(irq_active), 0);
  endtask

  task automatic quiet(input string rq, input int cycles);
    int act = 0;
    for (int t = 0; t < cycles; t++) begin
      step();
      if (irq_active || stack_start) act = 1;
    end
    chk(rq, act, 0);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    chk("R7 reset active", int'(irq_active), 0);
    chk("R7 reset dispatch", int'(dispatch), 0);
    chk("R7 reset stack_start", int'(stack_start), 0);
    chk("R7 reset vector", int'(handler_vector), 0);

    // R1 R2 R12: every ordered pair of simultaneous edges
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        pulse((N'(1) << i) | (N'(1) << j));
        wait_ss();
        do_stack(i < j ? i : j);
        if (i != j) end_handler(i < j ? j : i);
        end_handler(-1);
        do_unstack();
        quiet("R2 R12 single service", 2);
      end
    end

    // R3: level line held high chains to itself, then releases
    irq_edge_sel[5] = 1'b0;
    irq_in[5] = 1'b1;
    wait_ss();
    do_stack(5);
    end_handler(5);
    irq_in[5] = 1'b0;
    end_handler(-1);
    do_unstack();
    // R3: no sticky copy of a level seen while disabled
    irq_en[5] = 1'b0;
    irq_in[5] = 1'b1;
    step();
    irq_in[5] = 1'b0;
    irq_en[5] = 1'b1;
    quiet("R3 no latch", 4);
    irq_edge_sel[5] = 1'b1;

    // R4: disabled edge stays pending, served after enable
    irq_en[2] = 1'b0;
    pulse(N'(1) << 2);
    quiet("R4 disabled", 5);
    irq_en[2] = 1'b1;
    wait_ss();
    do_stack(2);
    end_handler(-1);
    do_unstack();

    // R5: software clear discards a pending edge
    irq_en[6] = 1'b0;
    pulse(N'(1) << 6);
    step();
    sw_clr[6] = 1'b1;
    step();
    sw_clr[6] = 1'b0;
    irq_en[6] = 1'b1;
    quiet("R5 cleared", 4);

    // R6: edge and clear in the same cycle, edge wins
    irq_en[4] = 1'b0;
    sw_clr[4] = 1'b1;
    pulse(N'(1) << 4);
    sw_clr[4] = 1'b0;
    quiet("R6 disabled hold", 2);
    irq_en[4] = 1'b1;
    wait_ss();
    do_stack(4);
    end_handler(-1);
    do_unstack();

    // R9: late arrival of higher priority during stacking
    pulse(N'(1) << 6);
    wait_ss();
    pulse(N'(1) << 1);
    step();
    chk("R9 still stacking", int'(dispatch), 0);
    do_stack(1);
    end_handler(6);
    end_handler(-1);
    do_unstack();

    // R10: pop preemption during unstacking
    pulse(N'(1) << 3);
    wait_ss();
    do_stack(3);
    end_handler(-1);
    pulse(N'(1) << 7);
    step();
    chk("R10 preempt dispatch", int'(dispatch), 1);
    chk("R10 preempt vector", int'(handler_vector), 7);
    chk("R10 no restack", int'(stack_start), 0);
    chk("R10 active", int'(irq_active), 1);
    end_handler(-1);
    do_unstack();
    quiet("R11 stays idle", 3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule